// File: doc/BRIEF.md
# Locking Branch Target Buffer

This block is a small, fully associative branch target buffer for an instruction fetch unit. Each entry is keyed by the word-aligned effective address of a branch and stores the address fetch should jump to. Fetch presents its effective address every cycle. One cycle later the block reports whether that address is a known branch and, if so, the redirect target.

The branch execution stage writes entries through an allocate port. Allocation never creates a second entry for an address that is already present. When execution finds that a redirected instruction was not a branch at all, it sends a phantom report, and the matching entry is dropped. Entries can be pinned with a lock. A locked entry ignores phantom reports and the global invalidate, and it is never picked as a replacement victim. Locking and unlocking are requested by effective address. A lock request for an address that is absent allocates it already locked. A global invalidate and a global unlock-all complete the control set.

Top module: `btb_lock`

## Requirements
- R1: After reset every entry is invalid and unlocked, `pred_hit` is 0, and the replacement pointer is at entry 0.
- R2: When `fetch_vld` is high and `fetch_addr` matches a valid entry, `pred_hit` is 1 and `pred_target` holds that entry's target in the following cycle. When `fetch_vld` is low or nothing matches, `pred_hit` is 0 in the following cycle.
- R3: Allocating an address that is not present stores it in the lowest-numbered invalid entry, with the given target, valid and unlocked.
- R4: Allocating an address that is already present rewrites that entry's target and creates no second entry. At most one entry ever matches an address.
- R5: When every entry is valid, a new address replaces the first unlocked entry at or after the round-robin pointer, wrapping past the last entry. The pointer then moves to the entry after the victim.
- R6: When every entry is valid and locked, an allocate or lock request for an absent address is dropped and the buffer contents are unchanged.
- R7: A phantom report for an address held by an unlocked entry invalidates that entry.
- R8: A phantom report for an address held by a locked entry leaves the entry valid and predicting.
- R9: When an allocation and a phantom report name the same address in the same cycle, the allocation wins and the entry is valid with the new target.
- R10: A lock request sets the lock bit of a present entry and leaves its target unchanged. For an absent address it allocates an entry with `lock_target`, already locked. When lock and allocate requests arrive in the same cycle, the lock request is served and the allocation is dropped.
- R11: An unlock request clears the lock bit of the entry holding that address, so later phantom reports evict it.
- R12: In a cycle with `inv_all` high, every unlocked entry becomes invalid, locked entries stay valid, and the allocate, lock, unlock and phantom requests of that cycle are ignored.
- R13: `unlock_all` clears every lock bit at the end of the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_vld | input | 1 | Fetch address valid |
| fetch_addr | input | ADDR_W | Fetch effective word address |
| pred_hit | output | 1 | Registered lookup hit |
| pred_target | output | TGT_W | Registered redirect target |
| alloc_vld | input | 1 | Allocate request |
| alloc_addr | input | ADDR_W | Branch address to allocate |
| alloc_target | input | TGT_W | Target to store |
| phantom_vld | input | 1 | Non-branch redirect report |
| phantom_addr | input | ADDR_W | Address of the wrongly redirected instruction |
| lock_vld | input | 1 | Lock request |
| lock_addr | input | ADDR_W | Address to lock |
| lock_target | input | TGT_W | Target used if the lock request allocates |
| unlock_vld | input | 1 | Unlock request |
| unlock_addr | input | ADDR_W | Address to unlock |
| inv_all | input | 1 | Invalidate all unlocked entries |
| unlock_all | input | 1 | Clear all lock bits |

## Verification
Lookups are tried on present addresses, absent neighbours and addresses that have just been evicted. This separates a true match from a stale one and shows whether the output register delays by exactly one cycle. A repeated allocation with targets that share no set bits shows whether a duplicate entry was created, because two matching entries would merge their targets. Filling all entries, then locking one entry and then all of them, shows whether the victim order and the pointer skip locked entries, and whether a request is dropped when no entry is free. Same-cycle pairs (allocate with phantom, lock with allocate, invalidate with allocate) show the priority between competing requests.

// File: rtl/btb_lock_pkg.sv
package btb_lock_pkg;
   // Which request owns the single write path in a cycle.
   typedef enum logic [0:0] {
      SRC_ALLOC = 1'b0,
      SRC_LOCK  = 1'b1
   } wr_src_e;
endpackage

// File: rtl/btb_match.sv
module btb_match #(
   parameter int NUM_ENTRIES = 16,
   parameter int ADDR_W      = 30
) (
   input  logic [NUM_ENTRIES-1:0] ent_vld,
   input  logic [ADDR_W-1:0]      ent_tag [NUM_ENTRIES],
   input  logic [ADDR_W-1:0]      key,
   output logic [NUM_ENTRIES-1:0] hit_vec
);
   // One comparator per entry, all in parallel.
   for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
      assign hit_vec[g] = ent_vld[g] && (ent_tag[g] == key);
   end
endmodule

// File: rtl/btb_victim.sv
module btb_victim #(
   parameter int NUM_ENTRIES = 16,
   localparam int IW = $clog2(NUM_ENTRIES)
) (
   input  logic [NUM_ENTRIES-1:0] ent_vld,
   input  logic [NUM_ENTRIES-1:0] ent_lck,
   input  logic [IW-1:0]          rr_ptr,
   output logic                   found,
   output logic                   replace,
   output logic [IW-1:0]          idx
);
   always_comb begin
      logic [IW-1:0] j;
      found   = 1'b0;
      replace = 1'b0;
      idx     = '0;
      j       = '0;
      // Lowest-numbered free entry first (descending scan: lowest wins).
      for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
         if (!ent_vld[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
      // Otherwise the first unlocked entry at or after the pointer.
      if (!found) begin
         for (int k = NUM_ENTRIES - 1; k >= 0; k--) begin
            j = rr_ptr + IW'(k);
            if (!ent_lck[j]) begin
               found   = 1'b1;
               replace = 1'b1;
               idx     = j;
            end
         end
      end
   end
endmodule

// File: rtl/btb_lock.sv
module btb_lock
   import btb_lock_pkg::*;
#(
   parameter int NUM_ENTRIES = 16,
   parameter int ADDR_W      = 30,
   parameter int TGT_W       = 30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_vld,
   input  logic [ADDR_W-1:0] fetch_addr,
   output logic              pred_hit,
   output logic [TGT_W-1:0]  pred_target,
   input  logic              alloc_vld,
   input  logic [ADDR_W-1:0] alloc_addr,
   input  logic [TGT_W-1:0]  alloc_target,
   input  logic              phantom_vld,
   input  logic [ADDR_W-1:0] phantom_addr,
   input  logic              lock_vld,
   input  logic [ADDR_W-1:0] lock_addr,
   input  logic [TGT_W-1:0]  lock_target,
   input  logic              unlock_vld,
   input  logic [ADDR_W-1:0] unlock_addr,
   input  logic              inv_all,
   input  logic              unlock_all
);
   localparam int IW = $clog2(NUM_ENTRIES);

   // Elaboration checks on the parameters.
   if (NUM_ENTRIES < 2 || (NUM_ENTRIES & (NUM_ENTRIES - 1)) != 0) begin : g_bad_depth
      $error("btb_lock: NUM_ENTRIES must be a power of two, at least 2");
   end
   if (ADDR_W < 1 || TGT_W < 1) begin : g_bad_width
      $error("btb_lock: address and target widths must be positive");
   end

   // Entry state.
   logic [NUM_ENTRIES-1:0] ent_vld, ent_lck;
   logic [ADDR_W-1:0]      ent_tag [NUM_ENTRIES];
   logic [TGT_W-1:0]       ent_tgt [NUM_ENTRIES];
   logic [IW-1:0]          rr_ptr;

   logic [NUM_ENTRIES-1:0] vld_n, lck_n;
   logic [ADDR_W-1:0]      tag_n [NUM_ENTRIES];
   logic [TGT_W-1:0]       tgt_n [NUM_ENTRIES];
   logic [IW-1:0]          rr_n;

   // Four independent match ports.
   logic [NUM_ENTRIES-1:0] fetch_hv, wr_hv, ph_hv, un_hv;

   // Single write path: a lock request beats an allocation (R10).
   wr_src_e           wr_src;
   logic              wr_req;
   logic [ADDR_W-1:0] wr_addr;
   logic [TGT_W-1:0]  wr_tgt;
   logic              wr_hit;

   assign wr_src  = lock_vld ? SRC_LOCK : SRC_ALLOC;
   assign wr_req  = lock_vld || alloc_vld;
   assign wr_addr = (wr_src == SRC_LOCK) ? lock_addr : alloc_addr;
   assign wr_tgt  = (wr_src == SRC_LOCK) ? lock_target : alloc_target;
   assign wr_hit  = |wr_hv;

   btb_match #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_m_fetch (
      .ent_vld(ent_vld), .ent_tag(ent_tag), .key(fetch_addr), .hit_vec(fetch_hv));
   btb_match #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_m_write (
      .ent_vld(ent_vld), .ent_tag(ent_tag), .key(wr_addr), .hit_vec(wr_hv));
   btb_match #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_m_phantom (
      .ent_vld(ent_vld), .ent_tag(ent_tag), .key(phantom_addr), .hit_vec(ph_hv));
   btb_match #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_m_unlock (
      .ent_vld(ent_vld), .ent_tag(ent_tag), .key(unlock_addr), .hit_vec(un_hv));

   // Victim choice for an absent address.
   logic          vic_found, vic_replace;
   logic [IW-1:0] vic_idx;

   btb_victim #(.NUM_ENTRIES(NUM_ENTRIES)) u_victim (
      .ent_vld(ent_vld), .ent_lck(ent_lck), .rr_ptr(rr_ptr),
      .found(vic_found), .replace(vic_replace), .idx(vic_idx));

   // Per-entry request vectors; all are masked in an invalidate cycle.
   logic [NUM_ENTRIES-1:0] wr_sel, ev_vec, unl_vec;

   always_comb begin
      wr_sel = '0;
      if (wr_req && !inv_all) begin
         if (wr_hit)         wr_sel = wr_hv;
         else if (vic_found) wr_sel = NUM_ENTRIES'(1) << vic_idx;
      end
   end

   assign ev_vec  = (phantom_vld && !inv_all) ? (ph_hv & ~ent_lck) : '0;
   assign unl_vec = (unlock_vld && !inv_all) ? un_hv : '0;

   // Next state.
   always_comb begin
      vld_n = ent_vld;
      lck_n = ent_lck;
      tag_n = ent_tag;
      tgt_n = ent_tgt;
      rr_n  = rr_ptr;
      if (inv_all) begin
         vld_n = ent_vld & ent_lck;
      end else begin
         lck_n = ent_lck & ~unl_vec;
         vld_n = ent_vld & ~ev_vec;
         for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (wr_sel[i]) begin
               vld_n[i] = 1'b1;
               if (wr_hit) begin
                  lck_n[i] = lck_n[i] || (wr_src == SRC_LOCK);
                  if (wr_src == SRC_ALLOC) tgt_n[i] = wr_tgt;
               end else begin
                  lck_n[i] = (wr_src == SRC_LOCK);
                  tag_n[i] = wr_addr;
                  tgt_n[i] = wr_tgt;
               end
            end
         end
         if (wr_req && !wr_hit && vic_found && vic_replace) begin
            rr_n = vic_idx + IW'(1);
         end
      end
      if (unlock_all) lck_n = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ent_vld <= '0;
         ent_lck <= '0;
         rr_ptr  <= '0;
         for (int i = 0; i < NUM_ENTRIES; i++) begin
            ent_tag[i] <= '0;
            ent_tgt[i] <= '0;
         end
      end else begin
         ent_vld <= vld_n;
         ent_lck <= lck_n;
         rr_ptr  <= rr_n;
         ent_tag <= tag_n;
         ent_tgt <= tgt_n;
      end
   end

   // Registered lookup result.
   logic [TGT_W-1:0] fetch_tgt;

   always_comb begin
      fetch_tgt = '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
         fetch_tgt = fetch_tgt | ({TGT_W{fetch_hv[i]}} & ent_tgt[i]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pred_hit    <= 1'b0;
         pred_target <= '0;
      end else begin
         pred_hit    <= fetch_vld && (|fetch_hv);
         pred_target <= fetch_tgt;
      end
   end
endmodule

// File: rtl/btb_lock_chk.sv
module btb_lock_chk #(
   parameter int NUM_ENTRIES = 16
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   fetch_vld,
   input logic                   pred_hit,
   input logic                   inv_all,
   input logic                   unlock_all,
   input logic                   phantom_vld,
   input logic                   wr_req,
   input logic [NUM_ENTRIES-1:0] fetch_hv,
   input logic [NUM_ENTRIES-1:0] wr_hv,
   input logic [NUM_ENTRIES-1:0] ph_hv,
   input logic [NUM_ENTRIES-1:0] ent_vld,
   input logic [NUM_ENTRIES-1:0] ent_lck
);
   AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (ent_vld == '0 && ent_lck == '0 && !pred_hit)); // R1

   AST_HIT_REGISTERED: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_vld && |fetch_hv) |=> pred_hit); // R2

   AST_NO_FETCH_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_vld |=> !pred_hit); // R2

   AST_UNIQUE_FETCH_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fetch_hv)); // R4

   AST_UNIQUE_WRITE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_hv)); // R4

   AST_FULL_LOCKED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !inv_all && wr_hv == '0 && (ent_vld & ent_lck) == '1)
      |=> (ent_vld == $past(ent_vld))); // R6

   AST_LOCKED_SURVIVES_PHANTOM: assert property (@(posedge clk) disable iff (!rst_n)
      (phantom_vld && !inv_all && |(ph_hv & ent_lck))
      |=> ((ent_vld & $past(ph_hv & ent_lck)) == $past(ph_hv & ent_lck))); // R8

   AST_INVALIDATE_KEEPS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      inv_all |=> (ent_vld == $past(ent_vld & ent_lck))); // R12

   AST_UNLOCK_ALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      unlock_all |=> (ent_lck == '0)); // R13
endmodule

bind btb_lock btb_lock_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
   .clk(clk), .rst_n(rst_n), .fetch_vld(fetch_vld), .pred_hit(pred_hit),
   .inv_all(inv_all), .unlock_all(unlock_all), .phantom_vld(phantom_vld),
   .wr_req(wr_req), .fetch_hv(fetch_hv), .wr_hv(wr_hv), .ph_hv(ph_hv),
   .ent_vld(ent_vld), .ent_lck(ent_lck));

// File: tb/btb_lock_tb_top.sv
`timescale 1ns/1ps
module btb_lock_tb_top;
   localparam int AW = 30;
   localparam int TW = 30;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fetch_vld, alloc_vld, phantom_vld, lock_vld, unlock_vld, inv_all, unlock_all;
   logic [AW-1:0] fetch_addr, alloc_addr, phantom_addr, lock_addr, unlock_addr;
   logic [TW-1:0] alloc_target, lock_target, pred_target;
   logic          pred_hit;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   btb_lock dut_i (
      .clk(clk), .rst_n(rst_n),
      .fetch_vld(fetch_vld), .fetch_addr(fetch_addr),
      .pred_hit(pred_hit), .pred_target(pred_target),
      .alloc_vld(alloc_vld), .alloc_addr(alloc_addr), .alloc_target(alloc_target),
      .phantom_vld(phantom_vld), .phantom_addr(phantom_addr),
      .lock_vld(lock_vld), .lock_addr(lock_addr), .lock_target(lock_target),
      .unlock_vld(unlock_vld), .unlock_addr(unlock_addr),
      .inv_all(inv_all), .unlock_all(unlock_all));

   // Vector table ops.
   localparam logic [2:0] OP_ALLOC = 3'd0, OP_LOOK = 3'd1, OP_PHANT = 3'd2,
                          OP_LOCK = 3'd3, OP_UNLOCK = 3'd4;

   typedef struct packed {
      logic [2:0]    op;
      logic [AW-1:0] addr;
      logic [TW-1:0] tgt;
      logic          hit;
      logic [3:0]    req;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VEC [NV] = '{
      '{OP_ALLOC,  30'h100, 30'h0F0,  1'b0, 4'd3},
      '{OP_LOOK,   30'h100, 30'h0F0,  1'b1, 4'd3},  // R3 new entry hits
      '{OP_LOOK,   30'h104, 30'h0,    1'b0, 4'd2},  // R2 absent neighbour misses
      '{OP_ALLOC,  30'h100, 30'h3000, 1'b0, 4'd4},
      '{OP_LOOK,   30'h100, 30'h3000, 1'b1, 4'd4},  // R4 target rewritten, no merge
      '{OP_PHANT,  30'h100, 30'h0,    1'b0, 4'd7},
      '{OP_LOOK,   30'h100, 30'h0,    1'b0, 4'd7},  // R7 evicted
      '{OP_LOCK,   30'h200, 30'h222,  1'b0, 4'd10},
      '{OP_LOOK,   30'h200, 30'h222,  1'b1, 4'd10}, // R10 lock allocates
      '{OP_PHANT,  30'h200, 30'h0,    1'b0, 4'd8},
      '{OP_LOOK,   30'h200, 30'h222,  1'b1, 4'd8},  // R8 locked survives phantom
      '{OP_UNLOCK, 30'h200, 30'h0,    1'b0, 4'd11},
      '{OP_PHANT,  30'h200, 30'h0,    1'b0, 4'd11},
      '{OP_LOOK,   30'h200, 30'h0,    1'b0, 4'd11}, // R11 unlocked then evicted
      '{OP_ALLOC,  30'h300, 30'h333,  1'b0, 4'd3},
      '{OP_LOOK,   30'h300, 30'h333,  1'b1, 4'd3}   // R3
   };

   task automatic clr();
      fetch_vld = 0; alloc_vld = 0; phantom_vld = 0; lock_vld = 0;
      unlock_vld = 0; inv_all = 0; unlock_all = 0;
      fetch_addr = '0; alloc_addr = '0; phantom_addr = '0; lock_addr = '0;
      unlock_addr = '0; alloc_target = '0; lock_target = '0;
   endtask

   task automatic chk(input bit ok, input string req, input logic [TW-1:0] act,
                      input logic [TW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic look(input logic [AW-1:0] a, input bit exp_hit,
                       input logic [TW-1:0] exp_tgt, input string req);
      @(negedge clk); clr(); fetch_vld = 1; fetch_addr = a;
      @(negedge clk);
      chk(pred_hit == exp_hit, req, TW'(pred_hit), TW'(exp_hit));
      if (exp_hit) chk(pred_target == exp_tgt, req, pred_target, exp_tgt);
      clr();
   endtask

   task automatic alloc(input logic [AW-1:0] a, input logic [TW-1:0] t);
      @(negedge clk); clr(); alloc_vld = 1; alloc_addr = a; alloc_target = t;
      @(negedge clk); clr();
   endtask

   task automatic phant(input logic [AW-1:0] a);
      @(negedge clk); clr(); phantom_vld = 1; phantom_addr = a;
      @(negedge clk); clr();
   endtask

   task automatic lockr(input logic [AW-1:0] a, input logic [TW-1:0] t);
      @(negedge clk); clr(); lock_vld = 1; lock_addr = a; lock_target = t;
      @(negedge clk); clr();
   endtask

   task automatic unlockr(input logic [AW-1:0] a);
      @(negedge clk); clr(); unlock_vld = 1; unlock_addr = a;
      @(negedge clk); clr();
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      clr();
      repeat (3) @(negedge clk);
      chk(pred_hit == 1'b0, "R1 hit during reset", TW'(pred_hit), '0);
      rst_n = 1;
      look(30'h0,   1'b0, '0, "R1 empty after reset");
      look(30'h100, 1'b0, '0, "R1 empty after reset");

      // Table walk.
      for (int v = 0; v < NV; v++) begin
         case (VEC[v].op)
            OP_ALLOC:  alloc(VEC[v].addr, VEC[v].tgt);
            OP_PHANT:  phant(VEC[v].addr);
            OP_LOCK:   lockr(VEC[v].addr, VEC[v].tgt);
            OP_UNLOCK: unlockr(VEC[v].addr);
            default:   look(VEC[v].addr, VEC[v].hit, VEC[v].tgt,
                            $sformatf("R%0d table row %0d", VEC[v].req, v));
         endcase
      end

      // R9: allocate and phantom on the same address in one cycle.
      alloc(30'h400, 30'h4);
      @(negedge clk); clr();
      alloc_vld = 1; alloc_addr = 30'h400; alloc_target = 30'h44;
      phantom_vld = 1; phantom_addr = 30'h400;
      @(negedge clk); clr();
      look(30'h400, 1'b1, 30'h44, "R9 present entry");
      @(negedge clk); clr();
      alloc_vld = 1; alloc_addr = 30'h500; alloc_target = 30'h5;
      phantom_vld = 1; phantom_addr = 30'h500;
      @(negedge clk); clr();
      look(30'h500, 1'b1, 30'h5, "R9 absent entry");

      // R10: lock beats allocation; lock keeps an existing target.
      @(negedge clk); clr();
      lock_vld = 1; lock_addr = 30'h600; lock_target = 30'h6;
      alloc_vld = 1; alloc_addr = 30'h700; alloc_target = 30'h7;
      @(negedge clk); clr();
      look(30'h600, 1'b1, 30'h6, "R10 lock served");
      look(30'h700, 1'b0, '0,    "R10 alloc dropped");
      alloc(30'h800, 30'h8);
      lockr(30'h800, 30'h88);
      phant(30'h800);
      look(30'h800, 1'b1, 30'h8, "R10 existing entry locked, target kept");

      // R12: invalidate with a competing allocation.
      @(negedge clk); clr();
      inv_all = 1; alloc_vld = 1; alloc_addr = 30'h900; alloc_target = 30'h9;
      @(negedge clk); clr();
      look(30'h300, 1'b0, '0,    "R12 unlocked cleared");
      look(30'h600, 1'b1, 30'h6, "R12 locked kept");
      look(30'h800, 1'b1, 30'h8, "R12 locked kept");
      look(30'h900, 1'b0, '0,    "R12 alloc ignored");

      // R13: unlock-all, then phantoms evict.
      @(negedge clk); clr(); unlock_all = 1;
      @(negedge clk); clr();
      phant(30'h600);
      phant(30'h800);
      look(30'h600, 1'b0, '0, "R13 lock cleared");
      look(30'h800, 1'b0, '0, "R13 lock cleared");

      // R3/R5: fill every entry, then replace around a locked entry.
      for (int i = 0; i < 16; i++) alloc(30'h1000 + AW'(i), 30'h100 + TW'(i));
      look(30'h1000, 1'b1, 30'h100, "R3 full fill first");
      look(30'h100F, 1'b1, 30'h10F, "R3 full fill last");
      lockr(30'h1000, 30'h0);
      alloc(30'h2000, 30'h2000);
      look(30'h1001, 1'b0, '0,      "R5 victim skips locked entry 0");
      look(30'h1000, 1'b1, 30'h100, "R5 locked entry kept");
      look(30'h2000, 1'b1, 30'h2000, "R5 new entry");
      alloc(30'h2100, 30'h2100);
      look(30'h1002, 1'b0, '0,      "R5 pointer advanced");
      look(30'h1003, 1'b1, 30'h103, "R5 next entry kept");

      // R6: everything locked, new addresses dropped.
      lockr(30'h2000, 30'h0);
      lockr(30'h2100, 30'h0);
      for (int i = 3; i < 16; i++) lockr(30'h1000 + AW'(i), 30'h0);
      alloc(30'h3000, 30'h3);
      look(30'h3000, 1'b0, '0,      "R6 alloc dropped");
      look(30'h1003, 1'b1, 30'h103, "R6 contents unchanged");
      look(30'h2100, 1'b1, 30'h2100, "R6 contents unchanged");
      lockr(30'h3100, 30'h31);
      look(30'h3100, 1'b0, '0,      "R6 lock allocation dropped");

      // R2: no fetch valid gives no hit.
      @(negedge clk); clr(); fetch_addr = 30'h1003;
      @(negedge clk);
      chk(pred_hit == 1'b0, "R2 fetch_vld low", TW'(pred_hit), '0);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule